// File: doc/BRIEF.md
# Serial Lane High-Speed Burst Sequencer

This block drives one serial data lane of a camera link that switches between a two-wire low-power signalling mode and a differential high-speed mode. At rest the lane sits in the stop state, with both single-ended lines high. When the upstream logic offers a byte, the sequencer takes it and signals a high-speed request by pulling the positive line low. It then pulls both lines low to form a bridge state, and enables the high-speed driver with a differential zero. Next it sends a fixed sync byte and serializes the payload bytes one bit per cycle. It finishes each burst with a trail of the inverted final bit and then releases the lane back to the stop state.

Payload arrives on a valid/ready byte stream that has a last flag. Back-pressure rules: `s_ready` is high in the stop state, where the first byte of a burst is accepted. After that it is high only in the final bit cycle of a byte that was not flagged last. In that cycle the following byte is loaded, so the bytes go out back to back. At any other time the sequencer ignores the stream. If the source does not offer a byte when one is due, the burst closes as if the previous byte had been the last. The lengths of the request, bridge, zero and trail phases come from static duration inputs. Each length is counted in clock cycles, and a length of zero counts as one. Each phase timer loads when its phase is entered.

Top module: `lane_hs_tx`

## Requirements
- R1: After reset and between bursts the lane is in the stop state: `lp_p`=1, `lp_n`=1, `hs_en`=0, `hs_bit`=0, and `s_ready`=1.
- R2: A burst starts in the cycle after a byte is accepted. It drives `lp_p`=0 with `lp_n`=1 for `req_len` cycles, then `lp_p`=0 with `lp_n`=0 for `bridge_len` cycles, always in that order and with neither phase skipped.
- R3: After the bridge phase, `hs_en`=1 and `hs_bit`=0 for `zero_len` cycles. Both low-power lines stay 0 for as long as `hs_en` is 1.
- R4: After the zero phase, the sync value 8'hB8 is sent LSB first, which puts the bit sequence 0,0,0,1,1,1,0,1 on `hs_bit`.
- R5: Payload bytes follow the sync byte immediately. Each byte is sent LSB first, one bit per cycle, with no gap between bytes. `s_ready` is 1 exactly in bit 7 of a byte that was not flagged last.
- R6: After the final payload bit, `hs_bit` carries the inverse of that bit, with `hs_en`=1, for `trail_len` cycles.
- R7: After the trail, the lane returns to the stop state. From the acceptance of the first byte until that return, a stream byte offered while `s_ready`=0 is neither accepted nor sent.
- R8: If `s_valid` is 0 in the bit-7 cycle of a non-last byte, the trail starts right after that byte, as if the byte had been flagged last.
- R9: A duration input of 0 gives a phase length of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte offered |
| s_last | input | 1 | Offered byte ends the burst |
| s_ready | output | 1 | Sequencer takes the offered byte this cycle |
| req_len | input | CNT_W | Cycles of the request state (lp_p=0, lp_n=1) |
| bridge_len | input | CNT_W | Cycles of the bridge state (both lines low) |
| zero_len | input | CNT_W | Cycles of the differential zero |
| trail_len | input | CNT_W | Cycles of the inverted trail bit |
| lp_p | output | 1 | Low-power level of the positive line |
| lp_n | output | 1 | Low-power level of the negative line |
| hs_en | output | 1 | High-speed driver enable |
| hs_bit | output | 1 | Serial high-speed bit |

## Verification
The bench feeds bursts with different phase lengths, including all lengths zero, and with payload bytes of all ones, all zeros and mixed patterns. It compares every output on every cycle against a sequence computed independently of the design.
- An off-by-one in a phase timer would stretch or shorten a low-power phase and move every later bit.
- Transmitting MSB first would scramble the sync byte.
- A ready flag that stays high through the burst would take the junk byte the bench holds on the stream during a single-byte burst.
- A source that goes quiet in mid-burst must produce an early trail rather than a stalled lane.
- A trail that repeats the last bit instead of inverting it would fail on both trail polarities.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [2:0] {
    PH_STOP,
    PH_REQ,
    PH_BRIDGE,
    PH_ZERO,
    PH_SYNC,
    PH_DATA,
    PH_TRAIL
  } lane_phase_t;
endpackage

// File: rtl/lane_phase_timer.sv
module lane_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] dur,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (dur == '0) ? '0 : dur - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R9
  long_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dur > 1) |=> !expired);

  // R9
  short_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dur <= 1) |=> expired);
endmodule

// File: rtl/lane_bit_shifter.sv
module lane_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] load_val,
  output logic         serial_bit,
  output logic         last_slot
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(W - 1);

  logic [W-1:0]     sh;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= load_val;
      idx <= '0;
    end else if (advance) begin
      sh  <= sh >> 1;
      idx <= idx + 1'b1;
    end
  end

  assign serial_bit = sh[0];
  assign last_slot  = (idx == LAST_IDX);

  // R5
  lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (serial_bit == $past(load_val[0])));
endmodule

// File: rtl/lane_hs_tx.sv
module lane_hs_tx #(
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  SYNC_WORD = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  input  logic [CNT_W-1:0] req_len,
  input  logic [CNT_W-1:0] bridge_len,
  input  logic [CNT_W-1:0] zero_len,
  input  logic [CNT_W-1:0] trail_len,
  output logic             lp_p,
  output logic             lp_n,
  output logic             hs_en,
  output logic             hs_bit
);
  import lane_pkg::*;

  localparam int BYTE_W = 8;

  lane_phase_t       ph, ph_nxt;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_dur;
  logic              sh_load, sh_adv, sh_bit, sh_last;
  logic [BYTE_W-1:0] sh_val;
  logic [BYTE_W-1:0] first_q;
  logic              last_q, trail_q;
  logic              take;

  lane_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .dur     (tmr_dur),
    .expired (tmr_done)
  );

  lane_bit_shifter #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (sh_load),
    .advance    (sh_adv),
    .load_val   (sh_val),
    .serial_bit (sh_bit),
    .last_slot  (sh_last)
  );

  assign s_ready = (ph == PH_STOP) || (ph == PH_DATA && sh_last && !last_q);
  assign take    = s_ready && s_valid;

  always_comb begin
    ph_nxt   = ph;
    tmr_load = 1'b0;
    tmr_dur  = '0;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_adv   = 1'b0;
    unique case (ph)
      PH_STOP: if (s_valid) begin
        ph_nxt   = PH_REQ;
        tmr_load = 1'b1;
        tmr_dur  = req_len;
      end
      PH_REQ: if (tmr_done) begin
        ph_nxt   = PH_BRIDGE;
        tmr_load = 1'b1;
        tmr_dur  = bridge_len;
      end
      PH_BRIDGE: if (tmr_done) begin
        ph_nxt   = PH_ZERO;
        tmr_load = 1'b1;
        tmr_dur  = zero_len;
      end
      PH_ZERO: if (tmr_done) begin
        ph_nxt  = PH_SYNC;
        sh_load = 1'b1;
        sh_val  = SYNC_WORD;
      end
      PH_SYNC: begin
        sh_adv = 1'b1;
        if (sh_last) begin
          ph_nxt  = PH_DATA;
          sh_load = 1'b1;
          sh_val  = first_q;
        end
      end
      PH_DATA: begin
        sh_adv = 1'b1;
        if (sh_last) begin
          if (take) begin
            sh_load = 1'b1;
            sh_val  = s_data;
          end else begin
            ph_nxt   = PH_TRAIL;
            tmr_load = 1'b1;
            tmr_dur  = trail_len;
          end
        end
      end
      PH_TRAIL: if (tmr_done) ph_nxt = PH_STOP;
      default: ph_nxt = PH_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_STOP;
      first_q <= '0;
      last_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      ph <= ph_nxt;
      if (ph == PH_STOP && take) begin
        first_q <= s_data;
        last_q  <= s_last;
      end
      if (ph == PH_DATA && sh_last) begin
        if (take) last_q <= s_last;
        trail_q <= ~sh_bit;
      end
    end
  end

  always_comb begin
    lp_p   = (ph == PH_STOP);
    lp_n   = (ph == PH_STOP) || (ph == PH_REQ);
    hs_en  = (ph == PH_ZERO) || (ph == PH_SYNC) || (ph == PH_DATA) || (ph == PH_TRAIL);
    hs_bit = 1'b0;
    if (ph == PH_SYNC || ph == PH_DATA) hs_bit = sh_bit;
    else if (ph == PH_TRAIL)            hs_bit = trail_q;
  end

  // R2
  req_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_p) |-> (lp_n && $past(lp_n)));

  // R2
  bridge_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lp_n) && !hs_en) |-> (!lp_p && $past(!lp_p)));

  // R3
  hs_after_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(!lp_p && !lp_n) && !hs_bit));

  // R3
  lines_low_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_p && !lp_n));

  // R7
  stop_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_p && lp_n && s_ready));

  // R7
  no_ready_in_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && !(lp_p && lp_n)) |-> !s_ready);
endmodule

// File: tb/lane_hs_tx_test.sv
module lane_hs_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  typedef struct {
    logic [4:0] v;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_valid = 1'b0;
  logic          s_last = 1'b0;
  logic          s_ready;
  logic [CW-1:0] req_len = '0, bridge_len = '0, zero_len = '0, trail_len = '0;
  logic          lp_p, lp_n, hs_en, hs_bit;

  int   checks = 0;
  int   fails = 0;
  exp_t q[$];
  logic [7:0] pay [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_hs_tx #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .req_len(req_len), .bridge_len(bridge_len), .zero_len(zero_len),
    .trail_len(trail_len), .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en), .hs_bit(hs_bit)
  );

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic void push(input logic [4:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
  endfunction

  // Monitor: pop one expected cycle per negedge and compare
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e = q.pop_front();
      act = {s_ready, lp_p, lp_n, hs_en, hs_bit};
      checks++;
      if (act !== e.v) begin
        fails++;
        $display("FAIL %s: {ready,lp_p,lp_n,hs_en,bit} actual %b expected %b at %0t",
                 e.tag, act, e.v, $time);
      end
    end
  end

  task automatic put_next(input int idx, input int n, input bit end_last, input bit junk);
    if (idx < n) begin
      s_valid = 1'b1;
      s_data  = pay[idx];
      s_last  = (idx == n - 1) && end_last;
    end else if (junk) begin
      s_valid = 1'b1;
      s_data  = 8'h5A;
      s_last  = 1'b0;
    end else begin
      s_valid = 1'b0;
    end
  endtask

  // Driver: pushes the expected cycle sequence, then feeds the stream
  task automatic run_burst(input int n, input bit end_last, input bit junk,
                           input int d1, input int d2, input int d3, input int dt,
                           input string dtag);
    int L;
    int idx;
    int c;
    logic rdy;
    @(negedge clk);
    req_len = CW'(d1); bridge_len = CW'(d2); zero_len = CW'(d3); trail_len = CW'(dt);
    s_data = pay[0];
    s_valid = 1'b1;
    s_last = (n == 1) && end_last;
    @(posedge clk);
    #1;
    for (int k = 0; k < eff(d1); k++) push(5'b00100, "R2");
    for (int k = 0; k < eff(d2); k++) push(5'b00000, "R2");
    for (int k = 0; k < eff(d3); k++) push(5'b00010, (d3 == 0) ? "R9" : "R3");
    for (int k = 0; k < 8; k++) push({4'b0001, 8'hB8 >> k & 8'h1} == 5'b0 ? 5'b0 : {4'b0001, 1'((8'hB8 >> k) & 8'h1)}, "R4");
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        push({(k == 7) && !(i == n - 1 && end_last), 3'b001, pay[i][k]}, end_last ? "R5" : "R8");
    for (int k = 0; k < eff(dt); k++) push({4'b0001, ~pay[n-1][7]}, "R6");
    push(5'b11100, "R7");
    L = eff(d1) + eff(d2) + eff(d3) + 8 + 8 * n + eff(dt) + 1;
    idx = 1;
    c = 1;
    put_next(idx, n, end_last, junk);
    while (c < L) begin
      @(negedge clk);
      rdy = s_ready;
      @(posedge clk);
      #1;
      c++;
      if (rdy && s_valid && idx < n) begin
        idx++;
        put_next(idx, n, end_last, junk);
      end
      if (c == L) s_valid = 1'b0;
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    checks++;
    if ({s_ready, lp_p, lp_n, hs_en, hs_bit} !== 5'b11100) begin
      fails++;
      $display("FAIL R1: reset outputs actual %b expected 11100",
               {s_ready, lp_p, lp_n, hs_en, hs_bit});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({s_ready, lp_p, lp_n, hs_en, hs_bit} !== 5'b11100) begin
      fails++;
      $display("FAIL R1: idle outputs actual %b expected 11100",
               {s_ready, lp_p, lp_n, hs_en, hs_bit});
    end

    // three bytes, distinct phase lengths
    pay[0] = 8'h3C; pay[1] = 8'h81; pay[2] = 8'h6E;
    run_burst(3, 1'b1, 1'b0, 2, 3, 4, 3, "R2");
    // single byte, all lengths zero, junk held on the stream (R7, R9)
    pay[0] = 8'h01;
    run_burst(1, 1'b1, 1'b1, 0, 0, 0, 0, "R9");
    // source goes quiet after a non-last byte (R8)
    pay[0] = 8'hC5; pay[1] = 8'h2A;
    run_burst(2, 1'b0, 1'b0, 1, 2, 1, 2, "R8");
    // all ones, all zeros and mixed payloads
    pay[0] = 8'hFF; pay[1] = 8'h00; pay[2] = 8'hA5; pay[3] = 8'h7F;
    run_burst(4, 1'b1, 1'b0, 1, 1, 1, 5, "R5");
    repeat (3) @(negedge clk);
    checks++;
    if ({s_ready, lp_p, lp_n, hs_en} !== 4'b1110) begin
      fails++;
      $display("FAIL R7: final idle actual %b expected 1110", {s_ready, lp_p, lp_n, hs_en});
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule